// File: doc/BRIEF.md
# Sampling Converter Control and Result Bus

This block is the digital control side of a 16-bit sampling converter. Two active-low style controls arrive from outside the chip: a chip select and a read/convert level. A falling chip select with read/convert low starts a conversion. With read/convert high, the same edge presents the last result on the data lines. While a conversion runs, both uses of chip select are ignored. The conversion engine is abstracted: the word on `sample_in` is captured in the cycle the conversion starts and is released as the result after a fixed number of clock cycles.

A busy flag drops for the length of a conversion. The result is placed on the data lines a few cycles before busy rises, so an external register can use the busy rising edge as its latch strobe. The bus has no internal tri-state nets. An output-enable flag says when `data_out` counts as driven. If both controls are still low a fixed number of cycles after busy rises, a fresh conversion starts by itself, with no acquisition time. Both controls pass through a synchronizer before any decision is made.

Top module: `adc_ctl_top`

## Requirements
- R1: With read/convert high, a conversion does not start. With read/convert low, a falling chip select on an idle block starts one: busy goes low and mode reads 1 (convert).
- R2: Falling chip-select edges during a conversion are ignored. The captured word is not replaced, the conversion length is unchanged and no extra result is produced.
- R3: data_oe is 0 whenever chip select is high, read/convert is low, or a conversion is running. The only exception is the last LEAD_CYC-1 cycles of a conversion.
- R4: busy stays low for exactly CONV_CYC clock cycles per conversion (330 by default).
- R5: If chip select is low and read/convert is high near the end of a conversion, data_oe is 1 and data_out holds the new result in the cycle before busy rises.
- R6: If both chip select and read/convert are low RETRIG_CYC cycles after busy rises (25 by default), a new conversion starts, so busy stays high for exactly RETRIG_CYC cycles.
- R7: If chip select is high, or read/convert is high, at that point, no conversion starts and busy stays high.
- R8: The sample_in word present at conversion start is delivered unchanged as the two's complement result (0x7FFF, 0x0000, 0xFFFF, 0x8000 all pass through). Later changes to sample_in have no effect on it.
- R9: mode is 1 (convert) exactly while busy is low and 0 (acquire) otherwise.
- R10: During reset busy is 1, data_oe is 0, data_out is 0 and mode is 0.
- R11: With the block idle, chip select low and read/convert high, data_oe is 1 and data_out shows the most recent result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Chip select, active low, asynchronous |
| rc | input | 1 | Read (1) / convert (0) select, asynchronous |
| sample_in | input | 16 | Word taken as the conversion result at start |
| busy | output | 1 | Low while a conversion runs |
| data_out | output | 16 | Result word |
| data_oe | output | 1 | 1 when data_out counts as driven |
| mode | output | 1 | 1 = convert, 0 = acquire |

## Verification
The hardest case to reach is the self-started conversion. It needs both controls to sit low across the end of a conversion and stay low for the whole re-trigger window. The bench therefore starts a conversion and deliberately leaves both controls low. It swaps in a new sample word as busy rises and counts the high cycles of busy until the second conversion begins. The early bus opening before busy rises is reached in a similar way: read/convert is raised while chip select stays low in mid-conversion. A monitor then inspects the bus in the cycle just before the busy edge.

// File: rtl/adc_ctl_pkg.sv
package adc_ctl_pkg;
  typedef enum logic {
    MODE_ACQ  = 1'b0,
    MODE_CONV = 1'b1
  } mode_e;
endpackage

// File: rtl/adc_ctl_sync.sv
module adc_ctl_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] sh;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (rst) sh <= RST_VAL;
        else     sh <= d;
      end
    end else begin : g_chain
      always_ff @(posedge clk) begin
        if (rst) sh <= {STAGES{RST_VAL}};
        else     sh <= {sh[STAGES-2:0], d};
      end
    end
  endgenerate

  assign q = sh[STAGES-1];
endmodule

// File: rtl/adc_ctl_decode.sv
module adc_ctl_decode (
  input  logic clk,
  input  logic rst,
  input  logic cs_s,
  input  logic rc_s,
  input  logic converting,
  input  logic retrig_due,
  output logic start
);
  logic cs_prev;
  logic cs_fall;

  always_ff @(posedge clk) begin
    if (rst) cs_prev <= 1'b1;
    else     cs_prev <= cs_s;
  end

  assign cs_fall = cs_prev & ~cs_s;

  // a start needs an idle engine; a falling select with convert level, or
  // the end of the re-trigger window with both controls still low
  assign start = ~converting & ~rc_s & (cs_fall | (retrig_due & ~cs_s));
endmodule

// File: rtl/adc_ctl_engine.sv
module adc_ctl_engine #(
  parameter int W          = 16,
  parameter int CONV_CYC   = 330,
  parameter int RETRIG_CYC = 25,
  parameter int LEAD_CYC   = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         start,
  input  logic [W-1:0] sample,
  output logic         converting,
  output logic         busy,
  output logic         published,
  output logic         retrig_due,
  output logic [W-1:0] hold,
  output logic [W-1:0] result
);
  localparam int CW = $clog2(CONV_CYC + 1);
  localparam int RW = $clog2(RETRIG_CYC + 1);
  localparam logic [CW-1:0] CNT_LOAD = CW'(CONV_CYC - 1);
  localparam logic [CW-1:0] CNT_LEAD = CW'(LEAD_CYC);
  localparam logic [RW-1:0] RT_LOAD  = RW'(RETRIG_CYC - 1);

  logic [CW-1:0] cnt;
  logic [RW-1:0] rcnt;
  logic          armed;

  always_ff @(posedge clk) begin
    if (rst) begin
      converting <= 1'b0;
      busy       <= 1'b1;
      published  <= 1'b0;
      armed      <= 1'b0;
      cnt        <= '0;
      rcnt       <= '0;
      hold       <= '0;
      result     <= '0;
    end else if (start) begin
      converting <= 1'b1;
      busy       <= 1'b0;
      published  <= 1'b0;
      armed      <= 1'b0;
      cnt        <= CNT_LOAD;
      hold       <= sample;
    end else if (converting) begin
      if (cnt == CNT_LEAD) begin
        result    <= hold;
        published <= 1'b1;
      end
      if (cnt == '0) begin
        converting <= 1'b0;
        busy       <= 1'b1;
        armed      <= 1'b1;
        rcnt       <= RT_LOAD;
      end else begin
        cnt <= cnt - 1'b1;
      end
    end else if (armed) begin
      if (rcnt == '0) armed <= 1'b0;
      else            rcnt  <= rcnt - 1'b1;
    end
  end

  assign retrig_due = armed & (rcnt == '0);
endmodule

// File: rtl/adc_ctl_bus.sv
module adc_ctl_bus #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         cs_s,
  input  logic         rc_s,
  input  logic         converting,
  input  logic         published,
  input  logic [W-1:0] result,
  output logic         data_oe,
  output logic [W-1:0] data_out
);
  logic oe_next;

  assign oe_next = ~cs_s & rc_s & (~converting | published);

  always_ff @(posedge clk) begin
    if (rst) begin
      data_oe  <= 1'b0;
      data_out <= '0;
    end else begin
      data_oe  <= oe_next;
      data_out <= result;
    end
  end
endmodule

// File: rtl/adc_ctl_top.sv
module adc_ctl_top #(
  parameter int W           = 16,
  parameter int CONV_CYC    = 330,
  parameter int RETRIG_CYC  = 25,
  parameter int LEAD_CYC    = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         cs_n,
  input  logic         rc,
  input  logic [W-1:0] sample_in,
  output logic         busy,
  output logic [W-1:0] data_out,
  output logic         data_oe,
  output logic         mode
);
  logic         cs_s, rc_s;
  logic         start, converting, published, retrig_due;
  logic [W-1:0] hold_w, result_w;
  adc_ctl_pkg::mode_e mode_v;

  adc_ctl_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_cs (
    .clk(clk), .rst(rst), .d(cs_n), .q(cs_s));
  adc_ctl_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_rc (
    .clk(clk), .rst(rst), .d(rc), .q(rc_s));

  adc_ctl_decode u_decode (
    .clk(clk), .rst(rst), .cs_s(cs_s), .rc_s(rc_s),
    .converting(converting), .retrig_due(retrig_due), .start(start));

  adc_ctl_engine #(
    .W(W), .CONV_CYC(CONV_CYC), .RETRIG_CYC(RETRIG_CYC), .LEAD_CYC(LEAD_CYC)
  ) u_engine (
    .clk(clk), .rst(rst), .start(start), .sample(sample_in),
    .converting(converting), .busy(busy), .published(published),
    .retrig_due(retrig_due), .hold(hold_w), .result(result_w));

  adc_ctl_bus #(.W(W)) u_bus (
    .clk(clk), .rst(rst), .cs_s(cs_s), .rc_s(rc_s),
    .converting(converting), .published(published), .result(result_w),
    .data_oe(data_oe), .data_out(data_out));

  assign mode_v = converting ? adc_ctl_pkg::MODE_CONV : adc_ctl_pkg::MODE_ACQ;
  assign mode   = mode_v;
endmodule

// File: rtl/adc_ctl_chk.sv
module adc_ctl_chk #(
  parameter int W        = 16,
  parameter int CONV_CYC = 330
) (
  input logic         clk,
  input logic         rst,
  input logic         busy,
  input logic         mode,
  input logic         data_oe,
  input logic         cs_s,
  input logic         rc_s,
  input logic         published,
  input logic [W-1:0] hold
);
  localparam int LW = $clog2(CONV_CYC + 2);
  logic [LW-1:0] low_cnt;

  always_ff @(posedge clk) begin
    if (rst)        low_cnt <= '0;
    else if (!busy) low_cnt <= low_cnt + 1'b1;
    else            low_cnt <= '0;
  end

  // R3
  oe_needs_read_chk: assert property (@(posedge clk) disable iff (rst)
    data_oe |-> ($past(rc_s) && !$past(cs_s)));

  // R3
  oe_in_conv_chk: assert property (@(posedge clk) disable iff (rst)
    (data_oe && !busy) |-> published);

  // R4
  busy_width_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> (low_cnt == LW'(CONV_CYC)));

  // R9
  mode_busy_chk: assert property (@(posedge clk) disable iff (rst)
    mode != busy);

  // R2
  hold_stable_chk: assert property (@(posedge clk) disable iff (rst)
    (!busy && $past(!busy)) |-> $stable(hold));
endmodule

bind adc_ctl_top adc_ctl_chk #(.W(W), .CONV_CYC(CONV_CYC)) u_chk (
  .clk(clk), .rst(rst), .busy(busy), .mode(mode), .data_oe(data_oe),
  .cs_s(cs_s), .rc_s(rc_s), .published(published), .hold(hold_w));

// File: tb/tb_adc_ctl_top.sv
module tb_adc_ctl_top;
  localparam int CLK_PERIOD = 10;
  localparam int W    = 16;
  localparam int CONV = 330;
  localparam int RET  = 25;
  localparam int LEAD = 4;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         cs_n = 1'b1;
  logic         rc = 1'b1;
  logic [W-1:0] sample_in = '0;
  logic         busy, data_oe, mode;
  logic [W-1:0] data_out;

  adc_ctl_top #(.W(W), .CONV_CYC(CONV), .RETRIG_CYC(RET), .LEAD_CYC(LEAD)) dut (
    .clk(clk), .rst(rst), .cs_n(cs_n), .rc(rc), .sample_in(sample_in),
    .busy(busy), .data_out(data_out), .data_oe(data_oe), .mode(mode));

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_chk  = 0;
  int n_fail = 0;
  logic [W-1:0] exp_q[$];
  bit lead_exp = 1'b0;
  bit done = 1'b0;

  task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_busy(logic lvl);
    int k = 0;
    while (busy !== lvl && k < 2000) begin
      @(negedge clk);
      k++;
    end
    if (k >= 2000) check(1'b0, "R4 busy never reached level", busy, lvl);
  endtask

  task automatic start_conv(logic [W-1:0] v);
    rc = 1'b0;
    tick(3);
    sample_in = v;
    cs_n = 1'b0;
    wait_busy(1'b0);
    exp_q.push_back(v);
    check(mode == 1'b1, "R1 start / R9 mode convert", mode, 1);
    sample_in = ~v;
  endtask

  // scoreboard monitor
  logic         prev_busy = 1'b1;
  logic         prev_oe = 1'b0;
  logic [W-1:0] prev_data = '0;
  logic [W-1:0] e_mon;
  int           low_cnt = 0;

  always @(negedge clk) begin
    if (rst) begin
      prev_busy = 1'b1;
      low_cnt   = 0;
    end else begin
      if (!busy) begin
        low_cnt++;
        if (low_cnt <= CONV - LEAD)
          check(!data_oe, "R3 bus closed during conversion", data_oe, 0);
      end
      if (busy && !prev_busy) begin
        check(low_cnt == CONV, "R4 busy low width", low_cnt, CONV);
        if (exp_q.size() == 0) begin
          check(1'b0, "R2 unexpected result", data_out, 0);
        end else begin
          e_mon = exp_q.pop_front();
          check(data_out == e_mon, "R8 result word", data_out, e_mon);
          if (lead_exp) begin
            check(prev_oe, "R5 bus open before busy rise", prev_oe, 1);
            check(prev_data == e_mon, "R5 data before busy rise", prev_data, e_mon);
          end
        end
        low_cnt = 0;
      end
      prev_busy = busy;
      prev_oe   = data_oe;
      prev_data = data_out;
    end
  end

  task automatic finish_up();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    check(1'b0, "watchdog expired", 0, 1);
    finish_up();
  end

  initial begin
    int hc;
    tick(5);
    // R10 reset state
    check(busy == 1'b1, "R10 busy in reset", busy, 1);
    check(data_oe == 1'b0, "R10 oe in reset", data_oe, 0);
    check(data_out == '0, "R10 data in reset", data_out, 0);
    check(mode == 1'b0, "R10 mode in reset", mode, 0);
    rst = 1'b0;
    tick(5);

    // positive full scale, plain conversion
    start_conv(16'h7FFF);
    cs_n = 1'b1; rc = 1'b1;
    wait_busy(1'b1);
    tick(2);

    // R11 read with idle block
    cs_n = 1'b0;
    tick(5);
    check(data_oe == 1'b1, "R11 bus open on read", data_oe, 1);
    check(data_out == 16'h7FFF, "R11 last result shown", data_out, 16'h7FFF);
    cs_n = 1'b1;
    tick(5);
    check(data_oe == 1'b0, "R3 bus closed with select high", data_oe, 0);
    cs_n = 1'b0;
    tick(5);
    rc = 1'b0;
    tick(5);
    check(data_oe == 1'b0, "R3 bus closed with convert level", data_oe, 0);
    check(busy == 1'b1, "R1 no start without falling select", busy, 1);
    cs_n = 1'b1; rc = 1'b1;
    tick(5);

    // R2 select edges ignored mid-conversion
    start_conv(16'h0000);
    tick(20);
    cs_n = 1'b1; tick(5);
    cs_n = 1'b0; tick(5);
    rc = 1'b1; cs_n = 1'b1; tick(5);
    cs_n = 1'b0; tick(5);
    cs_n = 1'b1;
    wait_busy(1'b1);
    tick(RET + 20);
    check(busy == 1'b1, "R2 no extra conversion", busy, 1);
    check(exp_q.size() == 0, "R2 no extra result", exp_q.size(), 0);

    // R5 early bus with read level raised mid-conversion
    start_conv(16'hFFFF);
    lead_exp = 1'b1;
    tick(10);
    rc = 1'b1;
    wait_busy(1'b1);
    tick(2);
    lead_exp = 1'b0;
    tick(RET + 20);
    check(busy == 1'b1, "R7 no restart with read level", busy, 1);
    check(data_oe == 1'b1, "R11 bus open after conversion", data_oe, 1);
    check(data_out == 16'hFFFF, "R11 result after conversion", data_out, 16'hFFFF);
    cs_n = 1'b1;
    tick(3);

    // R6 self restart with both controls low
    start_conv(16'h8000);
    wait_busy(1'b1);
    sample_in = 16'h1234;
    exp_q.push_back(16'h1234);
    hc = 0;
    while (busy && hc < 1000) begin
      tick(1);
      hc++;
    end
    check(hc == RET, "R6 high time before restart", hc, RET);
    check(mode == 1'b1, "R9 mode convert on restart", mode, 1);
    sample_in = 16'h5555;
    cs_n = 1'b1; rc = 1'b1;
    wait_busy(1'b1);
    tick(RET + 20);
    check(busy == 1'b1, "R7 no restart with select high", busy, 1);
    check(exp_q.size() == 0, "R8 all results delivered", exp_q.size(), 0);
    check(mode == 1'b0, "R9 mode acquire when idle", mode, 0);

    finish_up();
  end
endmodule